// File: doc/BRIEF.md
# Core Module System Control Register Block

This block holds the housekeeping registers of a processor core module. The host reaches it over a simple 32-bit register bus with byte offsets, and each register fills one aligned 32-bit word. The block returns a fixed identity word and a fixed status word. It holds two oscillator settings that a 16-bit key guards, and a control register that drives an LED and the boot remap. A bit in the control register asks for a system reset. The block also has two flag registers, each with its own set word and clear word, a reference counter that starts from zero at reset, and a read-only window of memory-module description bytes.

A read request is taken in one cycle. Its data and an error indication appear one clock later, together with a one-cycle valid strobe. A write takes effect on the clock edge where it is presented. The bus has no back-pressure, so the block accepts a request on every cycle where the select is high. The reference counter advances only on cycles where the reference-tick enable is high. The bus clock frequency therefore does not set the counter rate. The installed memory size is a parameter, and it fixes the reset value of the memory-configuration word and the last description byte.

Top module: `cm_sysctrl`

## Requirements
- R1: A read of word 0 returns 0x411A3001 and a read of word 4 returns 0x00100000. Each read presents its data with `bus_rvalid` high in the cycle after the request, and `bus_rvalid` is low in every other cycle.
- R2: A write to word 5 keeps only data bits 15:0 as the key. A read of word 5 returns 0x0001A05F when the kept key is 0xA05F, and otherwise returns the kept key with zeros above bit 15. The key resets to 0.
- R3: Word 2 (oscillator, reset value 0x01000048) and word 7 (auxiliary oscillator, reset value 0x0007FEFF) take a write only while the key is 0xA05F. Otherwise the write leaves them unchanged.
- R4: A write to word 3 keeps data bit 0 (LED) and bit 2 (remap), and all other bits read back as 0. `led_o` follows bit 0. `remap_o` follows bit 2, where 0 selects boot flash at address zero and 1 selects RAM.
- R5: A write to word 3 with data bit 3 set raises `reset_req_o` for exactly the next cycle. The bit is never stored.
- R6: A write to word 12 ORs the data into the flags register, and a write to word 13 clears the flag bits where the data is 1. Words 14 and 15 do the same for the non-volatile flags register. Reads of words 12 and 14 return the current values, and both registers reset to 0.
- R7: A read of word 10 returns a 32-bit counter. The counter is 0 at reset and adds 1 on every clock edge where `ref_tick` is high. The value returned is the count before that edge's increment.
- R8: Word 8 (memory configuration) resets to 0x00011122 ORed with a size code: 0x10 for 256 MB or more, 0x0C for 128 MB, 0x08 for 64 MB, 0x04 for 32 MB, and 0 below 32 MB. Word 9 resets to 0x00000112. Both words store a full 32-bit write.
- R9: Byte offsets 0x100 to 0x17F read entry (offset-0x100)/4 of a 32-byte description table in bits 7:0. The first entry is 0x80, and the last entry is 64, 32, 16, 4 or 2 for the same size steps as R8. Offsets 0x180 to 0x1FF read as 0.
- R10: Words 32 to 35 read as 0 and ignore writes.
- R11: A read of any word not named in R1 to R10 (word 1, 13, 15 or 0x200 and above, among others) returns 0 with `bus_err` high for one cycle alongside `bus_rvalid`. Writes to unmapped or read-only words change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_tick | input | 1 | Reference-rate enable for the counter |
| bus_sel | input | 1 | Request present this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response strobe |
| bus_err | output | 1 | Unmapped read indication |
| remap_o | output | 1 | 0 = boot flash at zero, 1 = RAM at zero |
| reset_req_o | output | 1 | One-cycle system reset request |
| led_o | output | 1 | LED drive |

## Verification
The assertions check the following on every cycle:
- The oscillator words change only while the key is open.
- A write to a set word never clears a flag.
- The counter moves by exactly one on a tick and holds otherwise.
- A read strobe, error flag or reset pulse never appears without a matching request in the cycle before.
- The remap level changes only after a write.

Only the bench's scenarios can show the values themselves: the key readback, the fixed and reset words, the description bytes and the exact counter value seen by a read.

// File: rtl/cmsc_pkg.sv
package cmsc_pkg;
  localparam int W_ID     = 0;
  localparam int W_OSC    = 2;
  localparam int W_CTRL   = 3;
  localparam int W_STAT   = 4;
  localparam int W_KEY    = 5;
  localparam int W_AUX    = 7;
  localparam int W_MEMCFG = 8;
  localparam int W_INIT   = 9;
  localparam int W_REFCNT = 10;
  localparam int W_FLAGS  = 12;
  localparam int W_VOLT   = 32;
  localparam int W_DESC   = 64;
  localparam int DESC_N   = 32;

  localparam logic [31:0] ID_WORD   = 32'h411A3001;
  localparam logic [31:0] STAT_WORD = 32'h00100000;
  localparam logic [15:0] OPEN_KEY  = 16'hA05F;

  function automatic logic [31:0] memcfg_code(input int mb);
    if (mb >= 256)     return 32'h10;
    else if (mb >= 128) return 32'h0C;
    else if (mb >= 64)  return 32'h08;
    else if (mb >= 32)  return 32'h04;
    else                return 32'h00;
  endfunction

  function automatic logic [7:0] desc_size(input int mb);
    if (mb >= 256)     return 8'd64;
    else if (mb >= 128) return 8'd32;
    else if (mb >= 64)  return 8'd16;
    else if (mb >= 32)  return 8'd4;
    else                return 8'd2;
  endfunction

  function automatic logic [7:0] desc_byte(input logic [4:0] idx, input int mb);
    case (idx)
      5'd0:  return 8'h80;  5'd1:  return 8'h08;  5'd2:  return 8'h04;
      5'd3:  return 8'h0B;  5'd4:  return 8'h09;  5'd5:  return 8'h01;
      5'd6:  return 8'h40;  5'd8:  return 8'h02;  5'd9:  return 8'hA0;
      5'd10: return 8'hA0;  5'd13: return 8'h08;  5'd15: return 8'h01;
      5'd16: return 8'h0E;  5'd17: return 8'h04;  5'd18: return 8'h1C;
      5'd19: return 8'h01;  5'd20: return 8'h02;  5'd21: return 8'h20;
      5'd22: return 8'hC0;  5'd27: return 8'h30;  5'd28: return 8'h28;
      5'd29: return 8'h30;  5'd30: return 8'h28;
      5'd31: return desc_size(mb);
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/cmsc_keyed_osc.sv
module cmsc_keyed_osc #(
  parameter logic [15:0] KEY     = 16'hA05F,
  parameter logic [31:0] OSC_RST = 32'h01000048,
  parameter logic [31:0] AUX_RST = 32'h0007FEFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_we,
  input  logic        osc_we,
  input  logic        aux_we,
  input  logic [31:0] wdata,
  output logic [15:0] key_q,
  output logic        unlocked,
  output logic [31:0] osc_q,
  output logic [31:0] aux_q
);
  logic armed;

  assign unlocked = (key_q == KEY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q <= '0;
      osc_q <= OSC_RST;
      aux_q <= AUX_RST;
      armed <= 1'b0;
    end else begin
      armed <= 1'b1;
      if (key_we) key_q <= wdata[15:0];
      if (osc_we && unlocked) osc_q <= wdata;
      if (aux_we && unlocked) aux_q <= wdata;
    end
  end

  // R3: the guarded words move only while the key was open
  a_r3_osc_guard: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (osc_q != $past(osc_q)) |-> $past(unlocked));
  a_r3_aux_guard: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (aux_q != $past(aux_q)) |-> $past(unlocked));
endmodule

// File: rtl/cmsc_setclr_reg.sv
module cmsc_setclr_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q     <= '0;
      armed <= 1'b0;
    end else begin
      armed <= 1'b1;
      if (set_we)      q <= q | wdata;
      else if (clr_we) q <= q & ~wdata;
    end
  end

  // R6: a set write never drops a flag, a clear write never raises one
  a_r6_set_keeps: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(set_we) |-> ((q & $past(q)) == $past(q)));
  a_r6_clr_no_raise: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(clr_we && !set_we) |-> ((q | $past(q)) == $past(q)));
endmodule

// File: rtl/cmsc_refcnt.sv
module cmsc_refcnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  output logic [W-1:0] cnt
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else begin
      armed <= 1'b1;
      if (tick) cnt <= cnt + 1'b1;
    end
  end

  // R7: one step per tick, no movement without one
  a_r7_step: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(tick) |-> (cnt == $past(cnt) + 1'b1));
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !$past(tick) |-> $stable(cnt));
endmodule

// File: rtl/cm_sysctrl.sv
module cm_sysctrl
  import cmsc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int MEM_MB = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic              bus_err,
  output logic              remap_o,
  output logic              reset_req_o,
  output logic              led_o
);
  localparam logic [31:0] MEMCFG_RST = 32'h00011122 | memcfg_code(MEM_MB);
  localparam logic [31:0] INIT_RST   = 32'h00000112;
  localparam int          NFLAG      = 2;

  int          widx;
  logic        wr_en, rd_en;
  logic [15:0] key_q;
  logic        unlocked;
  logic [31:0] osc_q, aux_q, cnt_q, memcfg_q, init_q;
  logic [31:0] flag_q [NFLAG];
  logic        ctrl_led, ctrl_remap;
  logic        rd_hit;
  logic [31:0] rd_val;
  logic        armed;

  assign widx  = int'(bus_addr >> 2);
  assign wr_en = bus_sel && bus_wr;
  assign rd_en = bus_sel && !bus_wr;

  cmsc_keyed_osc #(.KEY(OPEN_KEY)) u_osc (
    .clk(clk), .rst_n(rst_n),
    .key_we(wr_en && widx == W_KEY),
    .osc_we(wr_en && widx == W_OSC),
    .aux_we(wr_en && widx == W_AUX),
    .wdata(bus_wdata), .key_q(key_q), .unlocked(unlocked),
    .osc_q(osc_q), .aux_q(aux_q)
  );

  genvar g;
  generate
    for (g = 0; g < NFLAG; g++) begin : g_flags
      cmsc_setclr_reg #(.W(32)) u_flags (
        .clk(clk), .rst_n(rst_n),
        .set_we(wr_en && widx == W_FLAGS + 2*g),
        .clr_we(wr_en && widx == W_FLAGS + 2*g + 1),
        .wdata(bus_wdata), .q(flag_q[g])
      );
    end
  endgenerate

  cmsc_refcnt #(.W(32)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(ref_tick), .cnt(cnt_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_led    <= 1'b0;
      ctrl_remap  <= 1'b0;
      reset_req_o <= 1'b0;
      memcfg_q    <= MEMCFG_RST;
      init_q      <= INIT_RST;
      armed       <= 1'b0;
    end else begin
      armed       <= 1'b1;
      reset_req_o <= wr_en && widx == W_CTRL && bus_wdata[3];
      if (wr_en && widx == W_CTRL) begin
        ctrl_led   <= bus_wdata[0];
        ctrl_remap <= bus_wdata[2];
      end
      if (wr_en && widx == W_MEMCFG) memcfg_q <= bus_wdata;
      if (wr_en && widx == W_INIT)   init_q   <= bus_wdata;
    end
  end

  assign led_o   = ctrl_led;
  assign remap_o = ctrl_remap;

  always_comb begin
    rd_hit = 1'b1;
    rd_val = '0;
    if (widx >= W_DESC && widx < W_DESC + DESC_N) begin
      rd_val = {24'd0, desc_byte(5'(widx - W_DESC), MEM_MB)};
    end else if (widx >= W_DESC + DESC_N && widx < W_DESC + 2*DESC_N) begin
      rd_val = '0;
    end else if (widx >= W_VOLT && widx < W_VOLT + 4) begin
      rd_val = '0;
    end else begin
      case (widx)
        W_ID:       rd_val = ID_WORD;
        W_OSC:      rd_val = osc_q;
        W_CTRL:     rd_val = {29'd0, ctrl_remap, 1'b0, ctrl_led};
        W_STAT:     rd_val = STAT_WORD;
        W_KEY:      rd_val = {15'd0, unlocked, key_q};
        W_AUX:      rd_val = aux_q;
        W_MEMCFG:   rd_val = memcfg_q;
        W_INIT:     rd_val = init_q;
        W_REFCNT:   rd_val = cnt_q;
        W_FLAGS:    rd_val = flag_q[0];
        W_FLAGS+2:  rd_val = flag_q[1];
        default:    rd_hit = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      bus_err    <= 1'b0;
    end else begin
      bus_rvalid <= rd_en;
      bus_err    <= rd_en && !rd_hit;
      bus_rdata  <= (rd_en && rd_hit) ? rd_val : '0;
    end
  end

  // R1: a response strobe only follows a read request
  a_r1_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    bus_rvalid |-> $past(bus_sel && !bus_wr));
  // R11: an error carries a zero word and comes with the strobe
  a_r11_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (bus_rvalid && bus_rdata == 32'd0));
  // R5: a reset pulse only follows a write
  a_r5_req_after_write: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    reset_req_o |-> $past(bus_sel && bus_wr));
  // R4: the remap level changes only after a write
  a_r4_remap_needs_write: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !$past(bus_sel && bus_wr) |-> $stable(remap_o));
endmodule

// File: tb/cm_sysctrl_test.sv
module cm_sysctrl_test;
  localparam int MB = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, bus_err, remap_o, reset_req_o, led_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  int cyc = 0;

  always #10 clk = ~clk;

  cm_sysctrl #(.ADDR_W(12), .MEM_MB(MB)) uut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .bus_err(bus_err), .remap_o(remap_o), .reset_req_o(reset_req_o),
    .led_o(led_o)
  );

  // Reference model state
  logic [31:0] m_osc, m_aux, m_memcfg, m_init, m_flags, m_nv, m_cnt;
  logic [15:0] m_key;
  bit          m_led, m_remap;
  logic [31:0] e_rdata;
  bit          e_rvalid, e_err, e_rst;
  string       e_tag;
  byte unsigned desc [32] = '{8'h80, 8'h08, 8'h04, 8'h0B, 8'h09, 8'h01, 8'h40, 8'h00,
                              8'h02, 8'hA0, 8'hA0, 8'h00, 8'h00, 8'h08, 8'h00, 8'h01,
                              8'h0E, 8'h04, 8'h1C, 8'h01, 8'h02, 8'h20, 8'hC0, 8'h00,
                              8'h00, 8'h00, 8'h00, 8'h30, 8'h28, 8'h30, 8'h28, 8'd32};

  always @(posedge clk) begin
    int w;
    cyc++;
    w = int'(bus_addr) / 4;
    if (!rst_n) begin
      m_osc = 32'h01000048; m_aux = 32'h0007FEFF;
      m_memcfg = 32'h0001112E; m_init = 32'h112;
      m_flags = 0; m_nv = 0; m_cnt = 0; m_key = 0;
      m_led = 0; m_remap = 0;
      e_rdata = 0; e_rvalid = 0; e_err = 0; e_rst = 0; e_tag = "R1";
    end else begin
      e_rvalid = bus_sel && !bus_wr;
      e_err = 0; e_rdata = 0; e_rst = 0;
      if (bus_sel && !bus_wr) begin
        if (w >= 64 && w < 96) begin e_rdata = {24'd0, desc[w-64]}; e_tag = "R9"; end
        else if (w >= 96 && w < 128) begin e_rdata = 0; e_tag = "R9"; end
        else if (w >= 32 && w < 36) begin e_rdata = 0; e_tag = "R10"; end
        else begin
          case (w)
            0: begin e_rdata = 32'h411A3001; e_tag = "R1"; end
            4: begin e_rdata = 32'h00100000; e_tag = "R1"; end
            5: begin e_rdata = (m_key == 16'hA05F) ? 32'h1A05F : {16'd0, m_key}; e_tag = "R2"; end
            2: begin e_rdata = m_osc; e_tag = "R3"; end
            7: begin e_rdata = m_aux; e_tag = "R3"; end
            3: begin e_rdata = {29'd0, m_remap, 1'b0, m_led}; e_tag = "R4"; end
            8: begin e_rdata = m_memcfg; e_tag = "R8"; end
            9: begin e_rdata = m_init; e_tag = "R8"; end
            10: begin e_rdata = m_cnt; e_tag = "R7"; end
            12: begin e_rdata = m_flags; e_tag = "R6"; end
            14: begin e_rdata = m_nv; e_tag = "R6"; end
            default: begin e_rdata = 0; e_err = 1; e_tag = "R11"; end
          endcase
        end
      end
      if (bus_sel && bus_wr) begin
        case (w)
          5: m_key = bus_wdata[15:0];
          2: if (m_key == 16'hA05F) m_osc = bus_wdata;
          7: if (m_key == 16'hA05F) m_aux = bus_wdata;
          3: begin m_led = bus_wdata[0]; m_remap = bus_wdata[2]; e_rst = bus_wdata[3]; end
          8: m_memcfg = bus_wdata;
          9: m_init = bus_wdata;
          12: m_flags = m_flags | bus_wdata;
          13: m_flags = m_flags & ~bus_wdata;
          14: m_nv = m_nv | bus_wdata;
          15: m_nv = m_nv & ~bus_wdata;
          default: ;
        endcase
      end
      if (ref_tick) m_cnt = m_cnt + 1;
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Compare every cycle, 5 ns after the edge
  always @(posedge clk) begin
    #5;
    if (!done) begin
      chk("R1", "rvalid", {31'd0, bus_rvalid}, {31'd0, e_rvalid});
      chk("R11", "err", {31'd0, bus_err}, {31'd0, e_err});
      chk("R4", "led", {31'd0, led_o}, {31'd0, m_led});
      chk("R4", "remap", {31'd0, remap_o}, {31'd0, m_remap});
      chk("R5", "reset_req", {31'd0, reset_req_o}, {31'd0, e_rst});
      if (e_rvalid) chk(e_tag, "rdata", bus_rdata, e_rdata);
    end
  end

  // Reference tick: two of every three cycles
  always @(negedge clk) ref_tick <= (cyc % 3) != 0;

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 12'(a); bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input int a);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = 12'(a);
    @(negedge clk);
    bus_sel = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1, R3, R8, R2: reset and fixed values
    rd(12'h000); rd(12'h010); rd(12'h008); rd(12'h01C); rd(12'h020); rd(12'h024); rd(12'h014);
    // R3 locked writes ignored, R2 key readback
    wr(12'h008, 32'hDEAD0001); wr(12'h01C, 32'hBEEF0002); rd(12'h008); rd(12'h01C);
    wr(12'h014, 32'hFFFF1234); rd(12'h014);
    wr(12'h014, 32'h0000A05F); rd(12'h014);
    wr(12'h008, 32'h12345678); wr(12'h01C, 32'h9ABCDEF0); rd(12'h008); rd(12'h01C);
    wr(12'h014, 32'h0); wr(12'h008, 32'h0); rd(12'h008); rd(12'h014);
    // R4, R5 control
    wr(12'h00C, 32'hFFFFFFFF); rd(12'h00C);
    wr(12'h00C, 32'h00000008); rd(12'h00C);
    wr(12'h00C, 32'h00000004); wr(12'h00C, 32'h0000000C); rd(12'h00C);
    wr(12'h00C, 32'h1); rd(12'h00C);
    // R6 flags
    wr(12'h030, 32'h0000F00F); wr(12'h030, 32'h00000330); rd(12'h030);
    wr(12'h034, 32'h0000100F); rd(12'h030); rd(12'h038);
    wr(12'h038, 32'hA5A5A5A5); wr(12'h03C, 32'h000000FF); rd(12'h038); rd(12'h030);
    // R7 counter
    rd(12'h028); repeat (7) @(negedge clk); rd(12'h028); rd(12'h028);
    // R8 writable config words
    wr(12'h020, 32'h01020304); wr(12'h024, 32'h0); rd(12'h020); rd(12'h024);
    // R9 description window
    for (int i = 0; i < 32; i++) rd(12'h100 + 4*i);
    rd(12'h180); rd(12'h1FC);
    // R10 voltage words
    wr(12'h080, 32'hFFFFFFFF); wr(12'h08C, 32'h1); rd(12'h080); rd(12'h08C);
    // R11 unmapped reads and ignored writes
    rd(12'h004); rd(12'h034); rd(12'h03C); rd(12'h200); rd(12'hFFC);
    wr(12'h000, 32'h0); wr(12'h010, 32'h0); wr(12'h300, 32'hFFFFFFFF);
    rd(12'h000); rd(12'h010); rd(12'h030);
    // back-to-back reads
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = 12'h000;
    @(negedge clk); bus_addr = 12'h004;
    @(negedge clk); bus_addr = 12'h028;
    @(negedge clk); bus_sel = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule